// File: doc/BRIEF.md
# Signature-Skipping Next-PC Unit

This block holds the fetch program counter of a 32-bit core that has branch delay slots, and works out the next fetch address every time the core advances. The program image puts one reference-signature word between consecutive basic blocks, and the core itself must never fetch that word. A conditional branch that is not taken therefore steps over that word after its delay slot. A call writes a return address that also lies past that word. Taken branches, jumps and calls go to their targets unchanged, because targets already point at the first real instruction of a block.

A mode input turns this skipping on and off. When it is low, the unit sequences exactly like a conventional delay-slot core: the fall-through and link addresses are the branch address plus eight. The mode is read at the step that resolves each instruction, so a change applies from the next instruction boundary. The step input says when the core advances. While the step input is low, the unit holds its state.

The control-flow instruction that resolves in a step sits at address A = `pc_o - 4`, and its delay slot is the word being fetched at `pc_o`.

Top module: `nextpc_unit`

## Requirements
- R1: After reset, `pc_o` equals the parameter `RESET_PC` (default 0x0000_1000) and `link_we_o` is 0.
- R2: A step with `flow_i` = 2'b00 (sequential) sets `pc_o` to the previous `pc_o + 4`, whatever the values of `skip_en_i` and `taken_i`.
- R3: While `step_i` is 0, `pc_o` and `link_o` keep their values and `link_we_o` is 0 in the following cycle, whatever the other inputs are.
- R4: A step with `flow_i` = 2'b01 (conditional branch), `taken_i` = 0 and `skip_en_i` = 1 sets `pc_o` to the previous `pc_o + 8` (A + 12).
- R5: A step with `flow_i` = 2'b01, `taken_i` = 0 and `skip_en_i` = 0 sets `pc_o` to the previous `pc_o + 4` (A + 8).
- R6: A step with `flow_i` = 2'b01 and `taken_i` = 1 sets `pc_o` to `target_i`, with no skip added, in either mode.
- R7: A step with `flow_i` = 2'b10 (jump) sets `pc_o` to `target_i` in either mode, and `taken_i` has no effect.
- R8: A step with `flow_i` = 2'b11 (call) sets `pc_o` to `target_i` and `link_o` to A + 12 when `skip_en_i` = 1, or to A + 8 when it is 0. `link_we_o` is 1 for exactly the one cycle after a call step and 0 after any other step.
- R9: Bits [1:0] of `target_i` are ignored, so `pc_o` stays word aligned.
- R10: `skip_en_i` is read in the same step as the instruction it governs. Toggling it between two branch steps changes the skip of the second branch only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Core advances fetch this cycle |
| flow_i | input | 2 | Kind of instruction resolving: 00 sequential, 01 conditional branch, 10 jump, 11 call |
| taken_i | input | 1 | Branch condition result (used only for 01) |
| target_i | input | 32 | Branch, jump or call target |
| skip_en_i | input | 1 | Signature-skip mode enable |
| pc_o | output | 32 | Current fetch address |
| link_o | output | 32 | Return address written by the last call |
| link_we_o | output | 1 | Link register write strobe, one cycle after a call step |

## Verification
The bench targets the two places where the skip applies and checks that it appears nowhere else. A design that added the skip to sequential steps, to jumps or to taken branches would land one word past the block start. A design that dropped the skip from calls would return straight onto a signature word. The bench toggles the mode between consecutive branches, because a unit that latched the mode late would apply the old setting to the new branch. It also feeds misaligned targets and steps with `step_i` low, so that an unmasked target or a link strobe raised while the core is stalled shows up on the outputs.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'b00,
        FLOW_BRANCH = 2'b01,
        FLOW_JUMP   = 2'b10,
        FLOW_CALL   = 2'b11
    } flow_kind_e;

endpackage

// File: rtl/nextpc_incr.sv
module nextpc_incr #(
    parameter int XLEN       = 32,
    parameter int STEP_BYTES = 4,
    parameter int SKIP_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] seq_addr_o,
    output logic [XLEN-1:0] skip_addr_o
);
    localparam logic [XLEN-1:0] STEP_INC = XLEN'(STEP_BYTES);
    localparam logic [XLEN-1:0] SKIP_INC = XLEN'(STEP_BYTES + SKIP_BYTES);

    assign seq_addr_o = pc_i + STEP_INC;

    generate
        if (SKIP_BYTES == 0) begin : g_noskip
            assign skip_addr_o = seq_addr_o;
        end else begin : g_skip
            assign skip_addr_o = pc_i + SKIP_INC;
        end
    endgenerate
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
    import nextpc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [1:0]      flow_i,
    input  logic            taken_i,
    input  logic            skip_en_i,
    input  logic [XLEN-1:0] seq_addr_i,
    input  logic [XLEN-1:0] skip_addr_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic [XLEN-1:0] link_addr_o,
    output logic            is_call_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(WORD_BYTES - 1));

    logic [XLEN-1:0] fall_addr;
    logic [XLEN-1:0] tgt_aligned;

    always_comb begin
        fall_addr   = skip_en_i ? skip_addr_i : seq_addr_i;
        tgt_aligned = target_i & ALIGN_MASK;
        link_addr_o = fall_addr;
        is_call_o   = 1'b0;
        unique case (flow_kind_e'(flow_i))
            FLOW_SEQ:    next_pc_o = seq_addr_i;
            FLOW_BRANCH: next_pc_o = taken_i ? tgt_aligned : fall_addr;
            FLOW_JUMP:   next_pc_o = tgt_aligned;
            FLOW_CALL: begin
                next_pc_o = tgt_aligned;
                is_call_o = 1'b1;
            end
            default:     next_pc_o = seq_addr_i;
        endcase
    end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              WORD_BYTES = 4,
    parameter int              SIG_WORDS  = 1,
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            step_i,
    input  logic [1:0]      flow_i,
    input  logic            taken_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            skip_en_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] link_o,
    output logic            link_we_o
);
    localparam int SKIP_BYTES = SIG_WORDS * WORD_BYTES;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] link;
        logic            link_we;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] skip_addr;
    logic [XLEN-1:0] next_pc;
    logic [XLEN-1:0] link_addr;
    logic            is_call;

    nextpc_incr #(
        .XLEN      (XLEN),
        .STEP_BYTES(WORD_BYTES),
        .SKIP_BYTES(SKIP_BYTES)
    ) incr_i (
        .pc_i       (st_q.pc),
        .seq_addr_o (seq_addr),
        .skip_addr_o(skip_addr)
    );

    nextpc_select #(
        .XLEN      (XLEN),
        .WORD_BYTES(WORD_BYTES)
    ) sel_i (
        .flow_i     (flow_i),
        .taken_i    (taken_i),
        .skip_en_i  (skip_en_i),
        .seq_addr_i (seq_addr),
        .skip_addr_i(skip_addr),
        .target_i   (target_i),
        .next_pc_o  (next_pc),
        .link_addr_o(link_addr),
        .is_call_o  (is_call)
    );

    always_comb begin
        st_d         = st_q;
        st_d.link_we = 1'b0;
        if (step_i) begin
            st_d.pc = next_pc;
            if (is_call) begin
                st_d.link    = link_addr;
                st_d.link_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pc      <= RESET_PC;
            st_q.link    <= '0;
            st_q.link_we <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o      = st_q.pc;
    assign link_o    = st_q.link;
    assign link_we_o = st_q.link_we;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int SIG_WORDS  = 1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            step_i,
    input logic [1:0]      flow_i,
    input logic            taken_i,
    input logic [XLEN-1:0] target_i,
    input logic            skip_en_i,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] link_o,
    input logic            link_we_o
);
    localparam logic [XLEN-1:0] SEQ_INC  = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] SKIP_INC = XLEN'(WORD_BYTES * (1 + SIG_WORDS));
    localparam logic [XLEN-1:0] LOW_MASK = XLEN'(WORD_BYTES - 1);

    // R2
    seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && flow_i == 2'b00) |=> (pc_o == $past(pc_o) + SEQ_INC));

    // R3
    hold_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> ($stable(pc_o) && $stable(link_o) && !link_we_o));

    // R4
    nt_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && flow_i == 2'b01 && !taken_i && skip_en_i)
        |=> (pc_o == $past(pc_o) + SKIP_INC));

    // R6
    taken_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && flow_i == 2'b01 && taken_i)
        |=> (pc_o == ($past(target_i) & ~LOW_MASK)));

    // R8
    link_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && flow_i == 2'b11) |=> link_we_o);

    // R8
    no_stray_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && flow_i != 2'b11) |=> !link_we_o);

    // R9
    pc_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_o & LOW_MASK) == '0);
endmodule

bind nextpc_unit nextpc_unit_chk #(
    .XLEN      (XLEN),
    .WORD_BYTES(WORD_BYTES),
    .SIG_WORDS (SIG_WORDS)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .flow_i   (flow_i),
    .taken_i  (taken_i),
    .target_i (target_i),
    .skip_en_i(skip_en_i),
    .pc_o     (pc_o),
    .link_o   (link_o),
    .link_we_o(link_we_o)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        step_i = 1'b0;
    logic [1:0]  flow_i = 2'b00;
    logic        taken_i = 1'b0;
    logic [31:0] target_i = '0;
    logic        skip_en_i = 1'b0;
    logic [31:0] pc_o;
    logic [31:0] link_o;
    logic        link_we_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    nextpc_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .flow_i(flow_i),
        .taken_i(taken_i), .target_i(target_i), .skip_en_i(skip_en_i),
        .pc_o(pc_o), .link_o(link_o), .link_we_o(link_we_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // drive at negedge, one posedge, sample at the following negedge
    task automatic do_step(input logic [1:0] f, input logic t, input logic [31:0] tg, input logic m);
        step_i = 1'b1; flow_i = f; taken_i = t; target_i = tg; skip_en_i = m;
        @(posedge clk_i);
        @(negedge clk_i);
        step_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        check("R1 reset pc", pc_o, 32'h0000_1000);
        check("R1 reset link_we", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_seq();
        logic [31:0] p = pc_o;
        do_step(2'b00, 1'b1, 32'hDEAD_0000, 1'b1);
        check("R2 seq with mode on", pc_o, p + 4);
        p = pc_o;
        do_step(2'b00, 1'b0, 32'h0, 1'b0);
        check("R2 seq with mode off", pc_o, p + 4);
    endtask

    task automatic t_hold();
        logic [31:0] p = pc_o;
        logic [31:0] l = link_o;
        step_i = 1'b0; flow_i = 2'b11; taken_i = 1'b1; target_i = 32'h0000_9000; skip_en_i = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R3 hold pc", pc_o, p);
        check("R3 hold link", link_o, l);
        check("R3 no link strobe", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_nt_on();
        logic [31:0] p = pc_o;
        do_step(2'b01, 1'b0, 32'h0000_8000, 1'b1);
        check("R4 not-taken skip (A+12)", pc_o, p + 8);
    endtask

    task automatic t_nt_off();
        logic [31:0] p = pc_o;
        do_step(2'b01, 1'b0, 32'h0000_8000, 1'b0);
        check("R5 not-taken no skip (A+8)", pc_o, p + 4);
    endtask

    task automatic t_taken();
        do_step(2'b01, 1'b1, 32'h0000_2040, 1'b1);
        check("R6 taken mode on", pc_o, 32'h0000_2040);
        do_step(2'b01, 1'b1, 32'h0000_3100, 1'b0);
        check("R6 taken mode off", pc_o, 32'h0000_3100);
    endtask

    task automatic t_jump();
        do_step(2'b10, 1'b0, 32'h0000_4400, 1'b1);
        check("R7 jump mode on", pc_o, 32'h0000_4400);
        do_step(2'b10, 1'b1, 32'h0000_5500, 1'b0);
        check("R7 jump mode off", pc_o, 32'h0000_5500);
    endtask

    task automatic t_call(input logic m);
        logic [31:0] a = pc_o - 4;
        do_step(2'b11, 1'b0, 32'h0000_6000, m);
        check("R8 call target", pc_o, 32'h0000_6000);
        check("R8 call link", link_o, m ? a + 12 : a + 8);
        check("R8 link strobe high", {31'd0, link_we_o}, 32'd1);
        @(negedge clk_i);
        check("R8 link strobe single cycle", {31'd0, link_we_o}, 32'd0);
        do_step(2'b00, 1'b0, 32'h0, m);
        check("R8 no strobe after seq", {31'd0, link_we_o}, 32'd0);
    endtask

    task automatic t_misaligned();
        do_step(2'b10, 1'b0, 32'h0000_7003, 1'b1);
        check("R9 jump target low bits ignored", pc_o, 32'h0000_7000);
        do_step(2'b01, 1'b1, 32'h0000_7106, 1'b0);
        check("R9 branch target low bits ignored", pc_o, 32'h0000_7104);
    endtask

    task automatic t_mode_toggle();
        logic [31:0] p = pc_o;
        do_step(2'b01, 1'b0, 32'h0, 1'b0);
        check("R10 first branch mode off", pc_o, p + 4);
        p = pc_o;
        do_step(2'b01, 1'b0, 32'h0, 1'b1);
        check("R10 second branch mode on", pc_o, p + 8);
        p = pc_o;
        do_step(2'b01, 1'b0, 32'h0, 1'b0);
        check("R10 third branch mode off", pc_o, p + 4);
    endtask

    initial begin
        @(negedge clk_i);
        t_reset();
        t_seq();
        t_hold();
        t_nt_on();
        t_nt_off();
        t_taken();
        t_jump();
        t_call(1'b1);
        t_call(1'b0);
        t_misaligned();
        t_mode_toggle();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk_i);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule